// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps the contents of an asynchronous DRAM array alive. After reset it holds off for a power-up pause. It then runs a fixed number of initialization refresh cycles and raises a ready flag. From that point it schedules periodic refreshes, so that every row is visited within the retention period. With 4096 rows and 64 ms, one refresh is needed about every 15.6 µs.

The DRAM pins are shared with an access controller. Before the sequencer touches the strobes it raises a bus request. It waits for the grant and keeps the request high until the precharge of its cycle has ended. While access traffic withholds the grant, owed refreshes pile up in a saturating counter. They are paid back in a burst once the grant returns.

Two refresh styles are available through a mode input:
- **CAS-before-RAS:** the DRAM supplies the row. CAS falls ahead of RAS and WE stays high.
- **RAS-only:** the block drives the row from its own wrapping counter and pulses RAS with CAS held high.

The sequencer never drives data, so the data bus stays in high impedance during every refresh.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, busReq is 0, rasN and casN are 1, initDone is 0 and rowAddr is 0.
- R2: After reset is released, busReq stays 0 and no strobe moves for PAUSE_CYC cycles. The first request appears in cycle PAUSE_CYC+1.
- R3: After the pause, exactly INIT_CNT refresh cycles run back to back, with no wait on the interval timer. initDone rises after the last one's precharge and never falls before the next reset.
- R4: In a CAS-before-RAS cycle (refModeRasOnly=0 when the cycle starts), casN goes low exactly SETUP_CYC cycles before rasN falls. casN stays low for the whole RAS low time and rises together with rasN. weN is 1 whenever casN is 0.
- R5: Every RAS pulse of the sequencer is low for exactly RAS_CYC cycles. Between two pulses, rasN is high for at least PRE_CYC cycles.
- R6: In a RAS-only cycle (refModeRasOnly=1 when the cycle starts), casN stays 1 and rowAddr holds the row counter while RAS is low. The counter advances by one after each RAS-only cycle, wrapping from 2^ROW_W-1 to 0. CAS-before-RAS cycles leave it unchanged.
- R7: rasN and casN only go low while busReq is 1. A cycle starts only after busGnt is seen. Without a grant, busReq stays 1 and no strobe moves.
- R8: Once initDone is 1, one refresh becomes owed every INTERVAL_CYC cycles. With the grant given, one refresh cycle runs per interval.
- R9: Owed refreshes saturate at OWE_MAX. When a long-withheld grant returns, exactly OWE_MAX refresh cycles run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| refModeRasOnly | input | 1 | 1 selects RAS-only refresh, 0 selects CAS-before-RAS; sampled when a cycle starts |
| busGnt | input | 1 | Grant of the DRAM pins from the access controller |
| busReq | output | 1 | Request for the DRAM pins, held until the refresh precharge ends |
| initDone | output | 1 | Pause and initialization refreshes complete |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, held high (read polarity) |
| rowAddr | output | ROW_W | Row address for RAS-only refresh |

## Verification
The first request comes PAUSE_CYC+1 cycles after reset is released. Once busGnt is seen, casN (CAS-before-RAS only) falls on the next edge, and rasN follows SETUP_CYC edges later. initDone rises PRE_CYC edges after the last initialization RAS rise. An owed refresh appears one cycle after each INTERVAL_CYC boundary, counted from the first cycle of initDone.

The bench samples on the falling clock edge and measures strobe widths as runs of such samples. It opens its counting windows 20 cycles after an interval boundary, so that a refresh started by the timer can never straddle a window edge.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_REQ,
    ST_SETUP,
    ST_ACTIVE,
    ST_PRECH
  } rfshState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ldSetup;
    logic ldRas;
    logic ldPre;
    logic cycleDone;
  } rfshStrobe_t;

endpackage

// File: rtl/rfsh_datapath.sv
module rfsh_datapath
  import dram_rfsh_pkg::*;
#(
  parameter int PAUSE_CYC    = 25000,
  parameter int INTERVAL_CYC = 1950,
  parameter int INIT_CNT     = 8,
  parameter int OWE_MAX      = 8,
  parameter int ROW_W        = 12,
  parameter int SETUP_CYC    = 2,
  parameter int RAS_CYC      = 7,
  parameter int PRE_CYC      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rfshStrobe_t      strb,
  input  logic             modeRasOnly,
  output logic             pauseDone,
  output logic             phaseZero,
  output logic             initDone,
  output logic             owedNz,
  output logic             modeLat,
  output logic [ROW_W-1:0] rowAddr
);

  localparam int PH_MAX  = (SETUP_CYC > RAS_CYC) ?
                           ((SETUP_CYC > PRE_CYC) ? SETUP_CYC : PRE_CYC) :
                           ((RAS_CYC > PRE_CYC) ? RAS_CYC : PRE_CYC);
  localparam int PAUSE_W = $clog2(PAUSE_CYC + 1);
  localparam int PH_W    = $clog2(PH_MAX + 1);
  localparam int INIT_W  = $clog2(INIT_CNT + 1);
  localparam int TMR_W   = $clog2(INTERVAL_CYC + 1);
  localparam int OWE_W   = $clog2(OWE_MAX + 1);

  localparam logic [PAUSE_W-1:0] PAUSE_LAST = PAUSE_W'(PAUSE_CYC - 1);
  localparam logic [PH_W-1:0]    SETUP_LD   = PH_W'(SETUP_CYC - 1);
  localparam logic [PH_W-1:0]    RAS_LD     = PH_W'(RAS_CYC - 1);
  localparam logic [PH_W-1:0]    PRE_LD     = PH_W'(PRE_CYC - 1);
  localparam logic [INIT_W-1:0]  INIT_FULL  = INIT_W'(INIT_CNT);
  localparam logic [TMR_W-1:0]   TMR_LAST   = TMR_W'(INTERVAL_CYC - 1);
  localparam logic [OWE_W-1:0]   OWE_FULL   = OWE_W'(OWE_MAX);

  logic [PAUSE_W-1:0] pauseCnt;
  logic [PH_W-1:0]    phaseCnt;
  logic [INIT_W-1:0]  initCnt;
  logic [TMR_W-1:0]   tmrCnt;
  logic [OWE_W-1:0]   owedCnt;
  logic [ROW_W-1:0]   rowCnt;
  logic               tick;
  logic               payBack;

  // power-up pause
  assign pauseDone = (pauseCnt == PAUSE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pauseCnt <= '0;
    else if (!pauseDone) pauseCnt <= pauseCnt + 1'b1;
  end

  // phase timer shared by setup, RAS low and precharge
  assign phaseZero = (phaseCnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             phaseCnt <= '0;
    else if (strb.ldSetup)  phaseCnt <= SETUP_LD;
    else if (strb.ldRas)    phaseCnt <= RAS_LD;
    else if (strb.ldPre)    phaseCnt <= PRE_LD;
    else if (!phaseZero)    phaseCnt <= phaseCnt - 1'b1;
  end

  // initialization cycle count
  assign initDone = (initCnt == INIT_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          initCnt <= '0;
    else if (strb.cycleDone && !initDone) initCnt <= initCnt + 1'b1;
  end

  // interval timer, runs once initialization is complete
  assign tick = initDone && (tmrCnt == TMR_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tmrCnt <= '0;
    else if (tick)     tmrCnt <= '0;
    else if (initDone) tmrCnt <= tmrCnt + 1'b1;
  end

  // saturating count of owed refreshes
  assign payBack = strb.cycleDone && initDone;
  assign owedNz  = (owedCnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owedCnt <= '0;
    else begin
      unique case ({tick, payBack})
        2'b10:   if (owedCnt != OWE_FULL) owedCnt <= owedCnt + 1'b1;
        2'b01:   owedCnt <= owedCnt - 1'b1;
        default: owedCnt <= owedCnt;
      endcase
    end
  end

  // refresh style is frozen for the whole cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            modeLat <= 1'b0;
    else if (strb.ldSetup) modeLat <= modeRasOnly;
  end

  // row counter for RAS-only refresh, wraps naturally
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         rowCnt <= '0;
    else if (strb.cycleDone && modeLat) rowCnt <= rowCnt + 1'b1;
  end

  assign rowAddr = rowCnt;

endmodule

// File: rtl/rfsh_ctrl.sv
module rfsh_ctrl
  import dram_rfsh_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pauseDone,
  input  logic        phaseZero,
  input  logic        initDone,
  input  logic        owedNz,
  input  logic        modeLat,
  input  logic        busGnt,
  output rfshStrobe_t strb,
  output logic        busReq,
  output logic        rasN,
  output logic        casN
);

  rfshState_e st, stNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_PAUSE;
    else        st <= stNext;
  end

  always_comb begin
    stNext = st;
    strb   = '0;
    unique case (st)
      ST_PAUSE:  if (pauseDone) stNext = ST_IDLE;
      ST_IDLE:   if (!initDone || owedNz) stNext = ST_REQ;
      ST_REQ:    if (busGnt) begin
                   stNext       = ST_SETUP;
                   strb.ldSetup = 1'b1;
                 end
      ST_SETUP:  if (phaseZero) begin
                   stNext     = ST_ACTIVE;
                   strb.ldRas = 1'b1;
                 end
      ST_ACTIVE: if (phaseZero) begin
                   stNext     = ST_PRECH;
                   strb.ldPre = 1'b1;
                 end
      ST_PRECH:  if (phaseZero) begin
                   stNext         = ST_IDLE;
                   strb.cycleDone = 1'b1;
                 end
      default:   stNext = ST_IDLE;
    endcase
  end

  assign busReq = (st == ST_REQ) || (st == ST_SETUP) ||
                  (st == ST_ACTIVE) || (st == ST_PRECH);
  assign rasN   = (st != ST_ACTIVE);
  assign casN   = modeLat || !((st == ST_SETUP) || (st == ST_ACTIVE));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_rfsh_pkg::*;
#(
  parameter int PAUSE_CYC    = 25000,
  parameter int INTERVAL_CYC = 1950,
  parameter int INIT_CNT     = 8,
  parameter int OWE_MAX      = 8,
  parameter int ROW_W        = 12,
  parameter int SETUP_CYC    = 2,
  parameter int RAS_CYC      = 7,
  parameter int PRE_CYC      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refModeRasOnly,
  input  logic             busGnt,
  output logic             busReq,
  output logic             initDone,
  output logic             rasN,
  output logic             casN,
  output logic             weN,
  output logic [ROW_W-1:0] rowAddr
);

  rfshStrobe_t strb;
  logic pauseDone, phaseZero, owedNz, modeLat;

  rfsh_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pauseDone (pauseDone),
    .phaseZero (phaseZero),
    .initDone  (initDone),
    .owedNz    (owedNz),
    .modeLat   (modeLat),
    .busGnt    (busGnt),
    .strb      (strb),
    .busReq    (busReq),
    .rasN      (rasN),
    .casN      (casN)
  );

  rfsh_datapath #(
    .PAUSE_CYC    (PAUSE_CYC),
    .INTERVAL_CYC (INTERVAL_CYC),
    .INIT_CNT     (INIT_CNT),
    .OWE_MAX      (OWE_MAX),
    .ROW_W        (ROW_W),
    .SETUP_CYC    (SETUP_CYC),
    .RAS_CYC      (RAS_CYC),
    .PRE_CYC      (PRE_CYC)
  ) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .modeRasOnly (refModeRasOnly),
    .pauseDone   (pauseDone),
    .phaseZero   (phaseZero),
    .initDone    (initDone),
    .owedNz      (owedNz),
    .modeLat     (modeLat),
    .rowAddr     (rowAddr)
  );

  // refresh cycles never write
  assign weN = 1'b1;

endmodule

// File: rtl/rfsh_checker.sv
module rfsh_checker #(
  parameter int ROW_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busReq,
  input logic             initDone,
  input logic             rasN,
  input logic             casN,
  input logic             weN,
  input logic [ROW_W-1:0] rowAddr
);

  // R4
  cbr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rasN) && !casN) |-> $past(!casN));

  // R4
  we_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !casN |-> weN);

  // R7
  strobe_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rasN || !casN) |-> busReq);

  // R3
  init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    initDone |=> initDone);

  // R5
  precharge_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rasN) |=> rasN);

  // R6
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rowAddr) |-> (rowAddr == ROW_W'($past(rowAddr) + 1'b1)));

endmodule

bind dram_refresh_seq rfsh_checker #(.ROW_W(ROW_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .busReq   (busReq),
  .initDone (initDone),
  .rasN     (rasN),
  .casN     (casN),
  .weN      (weN),
  .rowAddr  (rowAddr)
);

// File: tb/dram_refresh_seq_tb_top.sv
module dram_refresh_seq_tb_top;

  localparam int PAUSE_CYC    = 100;
  localparam int INTERVAL_CYC = 400;
  localparam int INIT_CNT     = 8;
  localparam int OWE_MAX      = 4;
  localparam int ROW_W        = 3;
  localparam int SETUP_CYC    = 2;
  localparam int RAS_CYC      = 7;
  localparam int PRE_CYC      = 5;
  localparam int ROWS         = 1 << ROW_W;

  logic clk = 1'b0;
  logic rst_n, refModeRasOnly, busGnt;
  logic busReq, initDone, rasN, casN, weN;
  logic [ROW_W-1:0] rowAddr;

  always #4 clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CYC(PAUSE_CYC), .INTERVAL_CYC(INTERVAL_CYC), .INIT_CNT(INIT_CNT),
    .OWE_MAX(OWE_MAX), .ROW_W(ROW_W), .SETUP_CYC(SETUP_CYC),
    .RAS_CYC(RAS_CYC), .PRE_CYC(PRE_CYC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .refModeRasOnly(refModeRasOnly), .busGnt(busGnt),
    .busReq(busReq), .initDone(initDone), .rasN(rasN), .casN(casN),
    .weN(weN), .rowAddr(rowAddr)
  );

  int  total = 0;
  int  bad = 0;
  bit  autoGnt = 0;
  bit  finished = 0;
  int  cyc = 0;
  int  sinceInit = 0;
  int  pulses = 0;
  int  firstReq = -1;
  int  expRow = 0;
  int  rasLowRun = 0;
  int  rasHighRun = 1000;
  int  casLowRun = 0;
  bit  prevRas = 1'b1;
  bit  curCbr = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // grant follows the request with one half-cycle of delay when enabled
  initial begin
    busGnt = 1'b0;
    forever begin
      @(negedge clk);
      busGnt = autoGnt && busReq;
    end
  end

  // strobe monitor, sampled at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        cyc++;
        if (initDone) sinceInit++;
        if (busReq && firstReq < 0) firstReq = cyc;
        if (prevRas && !rasN) begin
          pulses++;
          check(rasHighRun >= PRE_CYC, "R5 precharge", rasHighRun, PRE_CYC);
          check(busReq && busGnt, "R7 strobe without grant", int'(busGnt), 1);
          curCbr = !casN;
          if (!casN) begin
            check(casLowRun == SETUP_CYC, "R4 cas lead", casLowRun, SETUP_CYC);
            check(weN == 1'b1, "R4 we high", int'(weN), 1);
          end else begin
            check(int'(rowAddr) == expRow, "R6 row address", int'(rowAddr), expRow);
            expRow = (expRow + 1) % ROWS;
          end
        end
        if (!prevRas && rasN) begin
          check(rasLowRun == RAS_CYC, "R5 ras width", rasLowRun, RAS_CYC);
          if (curCbr) begin
            check(casN == 1'b1, "R4 cas rises with ras", int'(casN), 1);
            check(casLowRun == SETUP_CYC + RAS_CYC, "R4 cas low span",
                  casLowRun, SETUP_CYC + RAS_CYC);
          end
        end
        rasLowRun  = rasN ? 0 : rasLowRun + 1;
        rasHighRun = rasN ? rasHighRun + 1 : 0;
        casLowRun  = casN ? 0 : casLowRun + 1;
        prevRas    = rasN;
      end
    end
  end

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic waitPhase(input int p);
    do begin
      @(negedge clk);
      #1;
    end while ((sinceInit % INTERVAL_CYC) != p);
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    refModeRasOnly = 1'b0;
    waitCycles(5);
    check(busReq == 1'b0, "R1 busReq", int'(busReq), 0);
    check(rasN == 1'b1 && casN == 1'b1, "R1 strobes", int'({rasN, casN}), 3);
    check(initDone == 1'b0, "R1 initDone", int'(initDone), 0);
    check(rowAddr == '0, "R1 rowAddr", int'(rowAddr), 0);
    rst_n = 1'b1;
  endtask

  task automatic test_pause_init();
    int guard = 0;
    autoGnt = 1'b1;
    while (!initDone && guard < 5000) begin
      @(negedge clk);
      #1;
      guard++;
    end
    check(firstReq >= PAUSE_CYC && firstReq <= PAUSE_CYC + 2, "R2 pause",
          firstReq, PAUSE_CYC + 1);
    check(initDone == 1'b1, "R3 initDone rises", int'(initDone), 1);
    check(pulses == INIT_CNT, "R3 init count", pulses, INIT_CNT);
  endtask

  task automatic test_periodic();
    int p0;
    waitPhase(20);
    p0 = pulses;
    waitCycles(4 * INTERVAL_CYC);
    check(pulses - p0 == 4, "R8 one refresh per interval", pulses - p0, 4);
    check(initDone == 1'b1, "R3 initDone sticky", int'(initDone), 1);
  endtask

  task automatic test_grant_hold();
    int p0;
    waitPhase(20);
    autoGnt = 1'b0;
    p0 = pulses;
    waitCycles(6 * INTERVAL_CYC);
    check(pulses == p0, "R7 no cycle without grant", pulses - p0, 0);
    check(busReq == 1'b1, "R7 request held", int'(busReq), 1);
    check(rasN == 1'b1 && casN == 1'b1, "R7 strobes idle", int'({rasN, casN}), 3);
    autoGnt = 1'b1;
    p0 = pulses;
    waitCycles(250);
    check(pulses - p0 == OWE_MAX, "R9 burst payback", pulses - p0, OWE_MAX);
  endtask

  task automatic test_ras_only();
    int p0;
    waitPhase(20);
    refModeRasOnly = 1'b1;
    p0 = pulses;
    waitCycles(10 * INTERVAL_CYC);
    check(pulses - p0 == 10, "R6 ras-only count", pulses - p0, 10);
    check(int'(rowAddr) == 10 % ROWS, "R6 row wrap", int'(rowAddr), 10 % ROWS);
  endtask

  task automatic test_cbr_keeps_row();
    int p0;
    logic [ROW_W-1:0] r0;
    waitPhase(20);
    refModeRasOnly = 1'b0;
    r0 = rowAddr;
    p0 = pulses;
    waitCycles(2 * INTERVAL_CYC);
    check(pulses - p0 == 2, "R8 cbr refreshes", pulses - p0, 2);
    check(rowAddr == r0, "R6 cbr keeps row", int'(rowAddr), int'(r0));
  endtask

  initial begin
    test_reset();
    test_pause_init();
    test_periodic();
    test_grant_hold();
    test_ras_only();
    test_cbr_keeps_row();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1'b1;
      check(1'b0, "watchdog", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule